// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block sequences a single DMA channel. Software loads a byte count, a source address, a destination address and a next-descriptor pointer through a small register-write port. A transfer then starts from any of three triggers: a software go strobe, an active-low external request, or a timer event. The channel moves the data in bursts, each issued as a read command to the source followed by a write command to the destination, on a simple request/acknowledge memory interface. Data buffering between the two commands belongs to the memory side and is not part of this block.

When the count of a record reaches zero and the next pointer is not null, the channel reads a four-word descriptor from memory into its registers and carries on. The chain ends at a null pointer. An active-low end-of-transfer input ends the whole chain early. It is sampled only between bursts, so a burst already under way always completes. The end of the chain is signalled by a one-cycle done pulse.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After a synchronous reset, busy, done and mem_req_valid are all 0, and no memory command is issued until a start trigger arrives.
- R2: While idle, a transfer starts on sw_go high, ext_req_n low or timer_trig high, and busy goes to 1. While busy, further triggers are ignored, and no extra commands follow the end of the chain.
- R3: Each burst issues one read command (kind 0) at the current source address, then one write command (kind 1) at the current destination address, both with the same length. The length is min(burst length, remaining count). Addresses are used as given, without any alignment, and both advance by the burst length after the write acknowledges.
- R4: The byte count is reduced by the burst length once per completed burst (after the write acknowledge). The record ends when the count is 0. A record that starts with a count of 0 issues no burst.
- R5: If eot_n is low when the channel is between bursts, the chain ends at once with a done pulse. A burst whose read has already been issued still completes its write. No descriptor is fetched after termination.
- R6: At the end of a record with a non-zero next pointer P, the channel issues four descriptor reads (kind 2, length 4) at P, P+4, P+8 and P+12, in that order. The returned words load the byte count (low 16 bits), source, destination and next pointer. The channel then runs the new record. A next pointer of 0 ends the chain.
- R7: Register writes (host_sel 0 count, 1 source, 2 destination, 3 next pointer) take effect only while idle. Writes made while busy change nothing.
- R8: The end of the chain produces exactly one done pulse of one cycle, and busy is 0 in that same cycle.
- R9: A configured burst length of 0 or above 64 is treated as 64.
- R10: While mem_req_valid is high and mem_req_ready is low, the command kind, address and length stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 7 | Burst length in bytes, 1 to 64 |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 2 | Register select: 0 count, 1 source, 2 destination, 3 next pointer |
| host_data | input | 32 | Register write data |
| sw_go | input | 1 | Software start strobe |
| ext_req_n | input | 1 | External start request, active low |
| timer_trig | input | 1 | Timer start event |
| eot_n | input | 1 | End-of-transfer, active low |
| mem_req_valid | output | 1 | Memory command valid |
| mem_req_kind | output | 2 | 0 burst read, 1 burst write, 2 descriptor word read |
| mem_req_addr | output | 32 | Command byte address |
| mem_req_len | output | 7 | Command length in bytes |
| mem_req_ready | input | 1 | Memory accepts the command |
| mem_ack | input | 1 | Command completed; for descriptor reads, data is valid |
| mem_rdata | input | 32 | Descriptor word returned with mem_ack |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle end-of-chain pulse |

## Verification
The hardest case to reach from the ports is an end-of-transfer that arrives while a burst is in flight. It must let that burst finish and must also stop a chain that would otherwise fetch a descriptor. The bench waits until the memory model has logged the first read command, drives eot_n low on the next falling edge, and programs a non-null next pointer. The only correct outcome is then exactly one read/write pair, no descriptor read, and one done pulse. A second hard case is a register write and a start strobe that arrive in the middle of a transfer. The bench issues them after two commands have been logged and checks that the command stream is unchanged and that nothing runs after done.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_DSC = 2'd2
  } cmd_kind_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ,
    S_WR_WAIT,
    S_DSC_REQ,
    S_DSC_WAIT
  } state_t;

  localparam int DSC_WORDS = 4;
  localparam int DSC_BYTES = 4;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [ADDR_W-1:0] host_data,
  input  logic              dsc_we,
  input  logic [1:0]        dsc_idx,
  input  logic [ADDR_W-1:0] dsc_data,
  input  logic              adv,
  input  logic [LEN_W-1:0]  adv_len,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] addr_q [2];

  // Source (select 1) and destination (select 2) share one structure.
  for (genvar g = 0; g < 2; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst)
        addr_q[g] <= '0;
      else if (host_we && host_sel == 2'(g + 1))
        addr_q[g] <= host_data;
      else if (dsc_we && dsc_idx == 2'(g + 1))
        addr_q[g] <= dsc_data;
      else if (adv)
        addr_q[g] <= addr_q[g] + ADDR_W'(adv_len);
    end
  end

  assign src = addr_q[0];
  assign dst = addr_q[1];

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (host_we && host_sel == 2'd0)
      count <= host_data[CNT_W-1:0];
    else if (dsc_we && dsc_idx == 2'd0)
      count <= dsc_data[CNT_W-1:0];
    else if (adv)
      count <= count - CNT_W'(adv_len);
  end

  always_ff @(posedge clk) begin
    if (rst)
      nxt <= '0;
    else if (host_we && host_sel == 2'd3)
      nxt <= host_data;
    else if (dsc_we && dsc_idx == 2'd3)
      nxt <= dsc_data;
  end
endmodule

// File: rtl/dma_chain_burst.sv
module dma_chain_burst #(
  parameter int CNT_W     = 16,
  parameter int MAX_BURST = 64,
  parameter int LEN_W     = 7
) (
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [CNT_W-1:0] count,
  output logic [LEN_W-1:0] blen
);
  logic [LEN_W-1:0] eff_len;

  always_comb begin
    if (cfg_len == '0 || cfg_len > LEN_W'(MAX_BURST))
      eff_len = LEN_W'(MAX_BURST);
    else
      eff_len = cfg_len;
    if (count < CNT_W'(eff_len))
      blen = count[LEN_W-1:0];
    else
      blen = eff_len;
  end
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              eot_n,
  input  logic              count_zero,
  input  logic              nxt_null,
  input  logic [LEN_W-1:0]  blen,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] nxt,
  input  logic              mem_req_ready,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              dsc_we,
  output logic [1:0]        dsc_idx,
  output logic [ADDR_W-1:0] dsc_data,
  output logic              adv,
  output logic [LEN_W-1:0]  adv_len
);
  state_t            state;
  logic [1:0]        idx;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  cur_len;

  // Register updates land on the same edge that enters S_CHECK.
  assign adv      = (state == S_WR_WAIT) && mem_ack;
  assign adv_len  = cur_len;
  assign dsc_we   = (state == S_DSC_WAIT) && mem_ack;
  assign dsc_idx  = idx;
  assign dsc_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      base      <= '0;
      cur_len   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      req_valid <= 1'b0;
      req_kind  <= CMD_RD;
      req_addr  <= '0;
      req_len   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            state <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (!eot_n || (count_zero && nxt_null)) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (!count_zero) begin
            cur_len   <= blen;
            req_valid <= 1'b1;
            req_kind  <= CMD_RD;
            req_addr  <= src;
            req_len   <= blen;
            state     <= S_RD_REQ;
          end else begin
            base      <= nxt;
            idx       <= '0;
            req_valid <= 1'b1;
            req_kind  <= CMD_DSC;
            req_addr  <= nxt;
            req_len   <= LEN_W'(DSC_BYTES);
            state     <= S_DSC_REQ;
          end
        end
        S_RD_REQ: begin
          if (mem_req_ready) begin
            req_valid <= 1'b0;
            state     <= S_RD_WAIT;
          end
        end
        S_RD_WAIT: begin
          if (mem_ack) begin
            req_valid <= 1'b1;
            req_kind  <= CMD_WR;
            req_addr  <= dst;
            req_len   <= cur_len;
            state     <= S_WR_REQ;
          end
        end
        S_WR_REQ: begin
          if (mem_req_ready) begin
            req_valid <= 1'b0;
            state     <= S_WR_WAIT;
          end
        end
        S_WR_WAIT: begin
          if (mem_ack) state <= S_CHECK;
        end
        S_DSC_REQ: begin
          if (mem_req_ready) begin
            req_valid <= 1'b0;
            state     <= S_DSC_WAIT;
          end
        end
        S_DSC_WAIT: begin
          if (mem_ack) begin
            if (idx == 2'(DSC_WORDS - 1)) begin
              state <= S_CHECK;
            end else begin
              idx       <= idx + 2'd1;
              req_valid <= 1'b1;
              req_kind  <= CMD_DSC;
              req_addr  <= base + ADDR_W'({idx + 2'd1, 2'b00});
              req_len   <= LEN_W'(DSC_BYTES);
              state     <= S_DSC_REQ;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MAX_BURST = 64,
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_burst_len,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [ADDR_W-1:0] host_data,
  input  logic              sw_go,
  input  logic              ext_req_n,
  input  logic              timer_trig,
  input  logic              eot_n,
  output logic              mem_req_valid,
  output logic [1:0]        mem_req_kind,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LEN_W-1:0]  mem_req_len,
  input  logic              mem_req_ready,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done
);
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] src, dst, nxt;
  logic [LEN_W-1:0]  blen, adv_len;
  logic              dsc_we, adv, start, reg_we;
  logic [1:0]        dsc_idx;
  logic [ADDR_W-1:0] dsc_data;

  assign reg_we = host_we && !busy;
  assign start  = !busy && (sw_go || !ext_req_n || timer_trig);

  dma_chain_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_we(reg_we), .host_sel(host_sel), .host_data(host_data),
    .dsc_we(dsc_we), .dsc_idx(dsc_idx), .dsc_data(dsc_data),
    .adv(adv), .adv_len(adv_len),
    .count(count), .src(src), .dst(dst), .nxt(nxt)
  );

  dma_chain_burst #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_burst (
    .cfg_len(cfg_burst_len), .count(count), .blen(blen)
  );

  dma_chain_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .eot_n(eot_n),
    .count_zero(count == '0), .nxt_null(nxt == '0),
    .blen(blen), .src(src), .dst(dst), .nxt(nxt),
    .mem_req_ready(mem_req_ready), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done),
    .req_valid(mem_req_valid), .req_kind(mem_req_kind),
    .req_addr(mem_req_addr), .req_len(mem_req_len),
    .dsc_we(dsc_we), .dsc_idx(dsc_idx), .dsc_data(dsc_data),
    .adv(adv), .adv_len(adv_len)
  );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req_valid,
  input logic [1:0]        mem_req_kind,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [LEN_W-1:0]  mem_req_len,
  input logic              mem_req_ready,
  input logic              busy,
  input logic              done
);
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid); // R2
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_kind != 2'd2) |-> (mem_req_len >= 1 && mem_req_len <= 64)); // R3
  AST_DESC_LEN: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_kind == 2'd2) |-> (mem_req_len == 4 && mem_req_addr[1:0] == 2'b00)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_kind) && $stable(mem_req_addr) && $stable(mem_req_len))); // R10
endmodule

bind dma_chain_ctrl dma_chain_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_dma_chain_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chain_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  cfg_burst_len = 7'd4;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_data = '0;
  logic        sw_go = 1'b0, ext_req_n = 1'b1, timer_trig = 1'b0, eot_n = 1'b1;
  logic        mem_req_valid, mem_req_ready, mem_ack, busy, done;
  logic [1:0]  mem_req_kind;
  logic [31:0] mem_req_addr, mem_rdata;
  logic [6:0]  mem_req_len;

  always #5 clk = ~clk;

  dma_chain_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_burst_len(cfg_burst_len),
    .host_we(host_we), .host_sel(host_sel), .host_data(host_data),
    .sw_go(sw_go), .ext_req_n(ext_req_n), .timer_trig(timer_trig), .eot_n(eot_n),
    .mem_req_valid(mem_req_valid), .mem_req_kind(mem_req_kind),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_req_ready(mem_req_ready), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  // Memory model: logs accepted commands, acks after a short latency.
  logic        stall_mode = 1'b0;
  logic [31:0] cyc = '0;
  logic [31:0] dmem [64];
  logic [1:0]  lk [64];
  logic [31:0] la [64];
  logic [6:0]  ll [64];
  int          nlog = 0;
  int          done_cnt = 0;
  logic        pend = 1'b0;
  int          lat = 0;
  logic [31:0] pdata = '0;

  assign mem_req_ready = stall_mode ? cyc[0] : 1'b1;

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ack <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
    if (!rst) begin
      if (pend) begin
        if (lat == 0) begin
          mem_ack <= 1'b1;
          mem_rdata <= pdata;
          pend <= 1'b0;
        end else lat <= lat - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (nlog < 64) begin
          lk[nlog] <= mem_req_kind;
          la[nlog] <= mem_req_addr;
          ll[nlog] <= mem_req_len;
        end
        nlog <= nlog + 1;
        pend <= 1'b1;
        lat <= 2;
        pdata <= dmem[mem_req_addr[7:2]];
      end
    end
  end

  // Expected command list
  logic [1:0]  ek [64];
  logic [31:0] ea [64];
  logic [6:0]  el [64];
  int ne = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_add(input logic [1:0] k, input logic [31:0] a, input logic [6:0] l);
    ek[ne] = k; ea[ne] = a; el[ne] = l; ne++;
  endtask

  task automatic exp_bursts(input int cnt, input int bl, input logic [31:0] s, input logic [31:0] d);
    int rem = cnt;
    int eb = (bl == 0 || bl > 64) ? 64 : bl;
    while (rem > 0) begin
      int n = (rem < eb) ? rem : eb;
      exp_add(2'd0, s, 7'(n));
      exp_add(2'd1, d, 7'(n));
      s += 32'(n); d += 32'(n); rem -= n;
    end
  endtask

  task automatic exp_desc(input logic [31:0] p);
    for (int i = 0; i < 4; i++) exp_add(2'd2, p + 32'(4 * i), 7'd4);
  endtask

  task automatic clear_logs();
    @(negedge clk);
    nlog = 0; ne = 0; done_cnt = 0;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_data = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic prog(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    wr_reg(2'd0, c); wr_reg(2'd1, s); wr_reg(2'd2, d); wr_reg(2'd3, n);
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    chk(nlog == ne, {tag, " command count"}, nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) begin
      chk(lk[i] == ek[i], {tag, " kind"}, lk[i], ek[i]);
      chk(la[i] == ea[i], {tag, " addr"}, la[i], ea[i]);
      chk(ll[i] == el[i], {tag, " len"}, ll[i], el[i]);
    end
    chk(done_cnt == 1, {tag, " R8 done pulses"}, done_cnt, 1);
    chk(busy == 1'b0, {tag, " R8 busy after done"}, busy, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(mem_req_valid == 0, "R1 valid", mem_req_valid, 0);
    repeat (5) @(negedge clk);
    chk(nlog == 0, "R1 no commands", nlog, 0);
  endtask

  task automatic t_sw_unaligned();
    clear_logs();
    cfg_burst_len = 7'd4;
    prog(32'd10, 32'h1001, 32'h2003, 32'h0);
    exp_bursts(10, 4, 32'h1001, 32'h2003);
    @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    chk(busy == 1, "R2 busy after sw_go", busy, 1);
    wait_done();
    compare("R3 R4 sw_go unaligned");
  endtask

  task automatic t_ext();
    clear_logs();
    cfg_burst_len = 7'd64;
    prog(32'd64, 32'h8000, 32'h9000, 32'h0);
    exp_bursts(64, 64, 32'h8000, 32'h9000);
    @(negedge clk); ext_req_n = 1'b0; @(negedge clk); ext_req_n = 1'b1;
    wait_done();
    compare("R2 ext_req_n");
  endtask

  task automatic t_timer_stall();
    clear_logs();
    cfg_burst_len = 7'd1;
    stall_mode = 1'b1;
    prog(32'd5, 32'h0A00, 32'h0B01, 32'h0);
    exp_bursts(5, 1, 32'h0A00, 32'h0B01);
    @(negedge clk); timer_trig = 1'b1; @(negedge clk); timer_trig = 1'b0;
    wait_done();
    stall_mode = 1'b0;
    compare("R2 R10 timer stalled");
  endtask

  task automatic t_clamp();
    clear_logs();
    cfg_burst_len = 7'd0;
    prog(32'd70, 32'h100, 32'h2000, 32'h0);
    exp_bursts(70, 0, 32'h100, 32'h2000);
    @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    wait_done();
    compare("R9 len 0 as 64");
  endtask

  task automatic t_chain();
    clear_logs();
    cfg_burst_len = 7'd4;
    dmem[16] = 32'd3; dmem[17] = 32'h3000; dmem[18] = 32'h4000; dmem[19] = 32'h80;
    dmem[32] = 32'd0; dmem[33] = 32'h5000; dmem[34] = 32'h6000; dmem[35] = 32'h0;
    prog(32'd6, 32'h1000, 32'h2000, 32'h40);
    exp_bursts(6, 4, 32'h1000, 32'h2000);
    exp_desc(32'h40);
    exp_bursts(3, 4, 32'h3000, 32'h4000);
    exp_desc(32'h80);
    @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    wait_done();
    compare("R6 chain");
  endtask

  task automatic t_eot();
    int t = 0;
    clear_logs();
    cfg_burst_len = 7'd4;
    prog(32'd20, 32'h700, 32'h900, 32'h40);
    exp_bursts(4, 4, 32'h700, 32'h900);
    @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    while (nlog < 1 && t < 100) begin @(negedge clk); t++; end
    eot_n = 1'b0;
    wait_done();
    eot_n = 1'b1;
    compare("R5 eot mid burst");
  endtask

  task automatic t_busy_ignore();
    int t = 0;
    clear_logs();
    cfg_burst_len = 7'd4;
    prog(32'd12, 32'h500, 32'h600, 32'h0);
    exp_bursts(12, 4, 32'h500, 32'h600);
    @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    while (nlog < 2 && t < 100) begin @(negedge clk); t++; end
    wr_reg(2'd0, 32'd1000);
    wr_reg(2'd1, 32'hFFFF0000);
    wr_reg(2'd3, 32'h40);
    @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    compare("R7 R2 writes and go while busy");
    clear_logs();
    @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    wait_done();
    compare("R4 zero count null next");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sw_unaligned();
    t_ext();
    t_timer_stall();
    t_clamp();
    t_chain();
    t_eot();
    t_busy_ignore();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule